// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the digital side of a byte-wide serial memory that answers as a target on a two-wire I2C bus. It oversamples SCL and SDA with the system clock, finds START and STOP conditions and decodes a 7-bit device address. The top four bits of that address are fixed and the low three come from strap pins, so eight parts can share one bus. A write transaction carries a two-byte word address, high byte first, and then one or more data bytes. A read transaction returns bytes from an internal address counter for as long as the master acknowledges them.

Write data goes into a 64-byte page buffer. A STOP that follows at least one complete data byte starts an internal write cycle, which copies the buffered bytes into the array. While that cycle runs the part does not acknowledge any device address, which lets the master poll for completion. A write-protect input is sampled once per write transaction. When it was high at that moment, the array is left unchanged and no write cycle starts.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe_o` = 0), and it releases SDA whenever no transaction is in progress.
- R2: The block acknowledges only an address byte whose bits 7..1 equal `{4'b1010, strap_i}`. Bit 0 of that byte selects read (1) or write (0). After an address it does not own, the block drives nothing until the next START, so a read from another address sees 0xFF.
- R3: A write of device address, word-address high byte, word-address low byte and one data byte, then STOP, stores the byte at word address `{hi,lo}` truncated to ADDR_W bits. A random read returns it afterwards.
- R4: During a multi-byte write, the low 6 address bits advance after each byte and wrap within the current 64-byte page while the upper bits stay fixed. A 65th or later byte overwrites the buffered byte at the same in-page offset.
- R5: After a STOP that starts a write cycle, the block does not acknowledge its device address for WR_CYC clock cycles (at least 64). It acknowledges again once the cycle ends.
- R6: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the low word-address byte. If it was 1 there, the array is unchanged and no write cycle starts. A change of `wp_i` after that edge has no effect on the current transaction.
- R7: With `wp_i` held low, writes proceed as in R3 and R4.
- R8: A read keeps sending bytes, MSB first, while the master acknowledges each byte. After a master non-acknowledge, the block releases SDA and waits for STOP or START.
- R9: The read address counter increments after each byte sent and wraps from the last array location to location 0.
- R10: A read that is not preceded by a word address (current-address read) starts at the counter value left by the previous access.
- R11: A STOP that comes before any complete data byte (for example after the address phase of a random read) starts no write cycle, so the next address is acknowledged at once.
- R12: The block pulls SDA low for the ninth clock of every byte it acknowledges. It changes `sda_oe_o` only while SCL is low, except when a START or STOP condition arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, 1 = array read-only |

## Verification
The bench builds the block with ADDR_W = 7 (a 128-byte array of two pages) and WR_CYC = 300. With this array size, the end-of-array wrap of the read counter and the in-page wrap of a write can both be reached in a few bytes. The two wraps land on different locations (0x00 versus 0x40), so a wrong wrap shows up as a wrong read value. The short write cycle lets the bench poll through a busy period and observe the first refused address and the later acknowledge within a few polls.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_MACK, ST_WAIT
  } bus_st_t;

  localparam logic [3:0] DEV_CLASS = 4'b1010;

  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
    return b[7:1] == {DEV_CLASS, strap};
  endfunction

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_o   = scl_p[1];
  assign sda_o   = sda_p[1];
  assign rise_o  = scl_p[1] & ~scl_p[2];
  assign fall_o  = ~scl_p[1] & scl_p[2];
  assign start_o = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_o  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/smem_store.sv
module smem_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/smem_commit.sv
module smem_commit #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6,
  parameter int WR_CYC = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     bw_en_i,
  input  logic [PAGE_W-1:0]        bw_idx_i,
  input  logic [7:0]               bw_data_i,
  input  logic                     go_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [7:0]               mem_data_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TOTAL = (WR_CYC > PAGE) ? WR_CYC : PAGE;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [7:0]               pbuf [PAGE];
  logic [PAGE-1:0]          valid;
  logic [CW-1:0]            cnt;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0]        idx;

  assign idx = cnt[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (bw_en_i) pbuf[bw_idx_i] <= bw_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
      valid  <= '0;
      page_q <= '0;
    end else begin
      if (clr_i) valid <= '0;
      if (bw_en_i) valid[bw_idx_i] <= 1'b1;
      if (go_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt    <= '0;
        page_q <= page_i;
      end else if (busy_o) begin
        if (cnt == CW'(TOTAL - 1)) begin
          busy_o <= 1'b0;
          valid  <= '0;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mem_we_o   = busy_o && (cnt < CW'(PAGE)) && valid[idx];
  assign mem_addr_o = {page_q, idx};
  assign mem_data_o = pbuf[idx];

  AST_BUF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bw_en_i |-> !busy_o); // R5
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6,
  parameter int WR_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import smem_pkg::*;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_t st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ahi, dout;
  logic [ADDR_W-1:0] ptr;
  logic rw, ack_drv, rd_drv, mst_ack, wr_pend, wp_lat;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data, rd_q;

  // named internal events
  logic rx_state, byte_done, load_ev, buf_wr, commit_go, buf_clr;
  assign rx_state  = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
  assign byte_done = scl_fall && !ack_drv && rx_state && (bitcnt == 4'd8);
  assign load_ev   = scl_fall && !start_ev && !stop_ev &&
                     ((ack_drv && st == ST_DEV && rw) ||
                      (!ack_drv && st == ST_MACK && bitcnt == 4'd1 && mst_ack));
  assign buf_wr    = byte_done && !start_ev && !stop_ev && (st == ST_WDAT);
  assign commit_go = stop_ev && wr_pend && !wp_lat;
  assign buf_clr   = start_ev && !busy;
  assign sda_oe_o  = ack_drv | rd_drv;

  smem_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  smem_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYC(WR_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr),
    .bw_en_i(buf_wr), .bw_idx_i(ptr[PAGE_W-1:0]), .bw_data_i(shreg),
    .go_i(commit_go), .page_i(ptr[ADDR_W-1:PAGE_W]),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  smem_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_addr),
    .wdata_i(mem_data), .raddr_i(ptr), .rdata_o(rd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  ahi <= '0;  dout <= '0;
      ptr <= '0;  rw <= 1'b0;  ack_drv <= 1'b0;  rd_drv <= 1'b0;
      mst_ack <= 1'b0;  wr_pend <= 1'b0;  wp_lat <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV;  bitcnt <= '0;  ack_drv <= 1'b0;  rd_drv <= 1'b0;  wr_pend <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE;  ack_drv <= 1'b0;  rd_drv <= 1'b0;  wr_pend <= 1'b0;
    end else if (scl_rise) begin
      if (st == ST_MACK) begin
        mst_ack <= !sda_s;
        bitcnt  <= 4'd1;
      end else if (rx_state && !ack_drv && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
    end else if (scl_fall) begin
      if (load_ev) begin
        st     <= ST_RDAT;
        ack_drv <= 1'b0;
        dout   <= {rd_q[6:0], 1'b0};
        rd_drv <= ~rd_q[7];
        bitcnt <= 4'd1;
        ptr    <= ptr + 1'b1;
      end else if (ack_drv) begin
        ack_drv <= 1'b0;
        bitcnt  <= '0;
        case (st)
          ST_DEV:  st <= ST_AHI;
          ST_AHI:  st <= ST_ALO;
          ST_ALO:  begin st <= ST_WDAT; wp_lat <= wp_i; end
          default: ;
        endcase
      end else if (byte_done) begin
        case (st)
          ST_DEV: begin
            if (dev_match(shreg, strap_i) && !busy) begin
              ack_drv <= 1'b1;
              rw      <= shreg[0];
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_AHI:  begin ahi <= shreg; ack_drv <= 1'b1; end
          ST_ALO:  begin ptr <= word_addr(ahi, shreg); ack_drv <= 1'b1; end
          default: begin ptr <= page_step(ptr); wr_pend <= 1'b1; ack_drv <= 1'b1; end
        endcase
      end else if (st == ST_RDAT) begin
        if (bitcnt < 4'd8) begin
          rd_drv <= ~dout[7];
          dout   <= {dout[6:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
        end else begin
          rd_drv <= 1'b0;
          st     <= ST_MACK;
          bitcnt <= '0;
        end
      end else if (st == ST_MACK && bitcnt == 4'd1) begin
        st <= ST_WAIT;
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o); // R1
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_drv) && st == ST_DEV) |-> !$past(busy)); // R5
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_ev) && !wp_lat)); // R6
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R4
  AST_DRV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_drv && rd_drv)); // R12
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_s); // R12
endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
  localparam int AW = 7;
  localparam int WC = 300;
  localparam int Q  = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_oe;
  wire  sda = !(m_low | sda_oe);
  int checks = 0, errors = 0;
  logic [7:0] model [128];
  logic [7:0] rd [80];

  always #10 clk = ~clk;

  serial_mem_target #(.ADDR_W(AW), .PAGE_W(6), .WR_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .wp_i(wp)
  );

  function automatic logic [7:0] gen(input logic [7:0] s, input int i);
    return s ^ 8'(i * 37 + 11);
  endfunction

  function automatic int page_loc(input int a, input int i);
    return (a & 8'hC0) | ((a + i) & 63);
  endfunction

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bstart(); m_low = 0; q(); scl = 1; q(); m_low = 1; q(); scl = 0; q(); endtask
  task automatic bstop();  m_low = 1; q(); scl = 1; q(); m_low = 0; q(); endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; q(); scl = 1; q(); q(); scl = 0; q();
    end
    m_low = 0; q(); scl = 1; q(); ack = (sda == 1'b0); q(); scl = 0; q();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 0; q(); scl = 1; q(); b[i] = sda; q(); scl = 0; q();
    end
    m_low = mack; q(); scl = 1; q(); q(); scl = 0; q();
  endtask

  task automatic page_write(input int a, input int n, input logic [7:0] s);
    logic ack;
    bstart(); wbyte(DEV_W, ack); chk("R12 ack of own write address", ack, 1);
    wbyte(8'h00, ack); wbyte(8'(a), ack);
    for (int i = 0; i < n; i++) wbyte(gen(s, i), ack);
    bstop();
  endtask

  task automatic model_write(input int a, input int n, input logic [7:0] s);
    for (int i = 0; i < n; i++) model[page_loc(a, i)] = gen(s, i);
  endtask

  task automatic wait_ready(input logic expect_busy);
    logic ack;
    int polls = 0;
    ack = 0;
    while (!ack && polls < 30) begin
      bstart(); wbyte(DEV_W, ack);
      if (polls == 0 && expect_busy) chk("R5 address refused during write cycle", ack, 0);
      if (polls == 0 && !expect_busy) chk("R6/R11 no write cycle started", ack, 1);
      bstop();
      polls++;
    end
    chk("R5 acknowledged after write cycle", ack, 1);
  endtask

  task automatic rand_read(input int a, input int n);
    logic ack;
    bstart(); wbyte(DEV_W, ack); wbyte(8'h00, ack); wbyte(8'(a), ack);
    bstart(); wbyte(DEV_R, ack);
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rd[i]);
    chk("R8 SDA released after master nack", sda_oe, 0);
    bstop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b, s;
    int a;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 SDA released after reset", sda_oe, 0);

    // R2: foreign strap value, read attempt
    bstart(); wbyte({4'b1010, 3'b000, 1'b1}, ack);
    chk("R2 foreign address not acknowledged", ack, 0);
    rbyte(1'b0, b); chk("R2 no drive after foreign address", b, 8'hFF);
    bstop();
    bstart(); wbyte({4'b1011, STRAP, 1'b0}, ack);
    chk("R2 wrong class nibble not acknowledged", ack, 0);
    bstop();

    // R11: address phase only, then STOP
    bstart(); wbyte(DEV_W, ack); chk("R12 ack drives SDA low", ack, 1);
    wbyte(8'h00, ack); wbyte(8'h05, ack); bstop();
    wait_ready(1'b0);

    // R3/R7: random single byte writes
    for (int k = 0; k < 5; k++) begin
      a = int'($urandom % 128);
      s = 8'($urandom);
      page_write(a, 1, s); model_write(a, 1, s);
      wait_ready(1'b1);
      rand_read(a, 1);
      chk("R3 byte write read back", rd[0], model[a]);
    end

    // R4: in-page wrap from offset 60 of page 1
    page_write(8'h7C, 6, 8'h3A); model_write(8'h7C, 6, 8'h3A);
    wait_ready(1'b1);
    rand_read(8'h7C, 4);
    for (int i = 0; i < 4; i++) chk("R4 page bytes before wrap", rd[i], model[8'h7C + i]);
    rand_read(8'h40, 2);
    chk("R4 in-page wrap to 0x40", rd[0], model[8'h40]);
    chk("R4 in-page wrap to 0x41", rd[1], model[8'h41]);
    chk("R4 wrap stays in page", model[8'h40], gen(8'h3A, 4));

    // R4: 66 bytes overwrite offsets 0 and 1
    page_write(8'h00, 66, 8'hC5); model_write(8'h00, 66, 8'hC5);
    wait_ready(1'b1);
    rand_read(8'h00, 3);
    chk("R4 overwrite offset 0", rd[0], gen(8'hC5, 64));
    chk("R4 overwrite offset 1", rd[1], gen(8'hC5, 65));
    chk("R4 offset 2 from first pass", rd[2], model[2]);

    // R6: protect sampled high, released before data byte
    wp = 1;
    bstart(); wbyte(DEV_W, ack); wbyte(8'h00, ack); wbyte(8'h10, ack);
    wp = 0;
    wbyte(8'h99, ack); bstop();
    wait_ready(1'b0);
    rand_read(8'h10, 1);
    chk("R6 protected location unchanged", rd[0], model[8'h10]);

    // R6: protect low at sample point, raised during data
    bstart(); wbyte(DEV_W, ack); wbyte(8'h00, ack); wbyte(8'h11, ack);
    wp = 1;
    wbyte(8'h3C, ack); bstop();
    wp = 0;
    model[8'h11] = 8'h3C;
    wait_ready(1'b1);
    rand_read(8'h11, 1);
    chk("R6 late protect ignored", rd[0], 8'h3C);

    // R9/R8: sequential read across end of array
    rand_read(8'h7E, 4);
    chk("R9 seq 0x7E", rd[0], model[8'h7E]);
    chk("R9 seq 0x7F", rd[1], model[8'h7F]);
    chk("R9 wrap to 0x00", rd[2], model[8'h00]);
    chk("R9 then 0x01", rd[3], model[8'h01]);

    // R10: current-address read continues at 0x02
    bstart(); wbyte(DEV_R, ack); chk("R10 read address acknowledged", ack, 1);
    rbyte(1'b1, rd[0]); rbyte(1'b0, rd[1]); bstop();
    chk("R10 current address 0x02", rd[0], model[2]);
    chk("R10 current address 0x03", rd[1], model[3]);

    // R8: random sequential read
    a = int'($urandom % 128);
    rand_read(a, 5);
    for (int i = 0; i < 5; i++) chk("R8 sequential data", rd[i], model[(a + i) % 128]);

    finish_run();
  end
endmodule